// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

This block adds or subtracts two 64-bit operands whose carry chain is cut into independent lanes at run time. A two-bit width selector chooses eight byte lanes, four halfword lanes, two word lanes or a single 64-bit lane. No carry crosses from one lane into the next. Three further controls choose the arithmetic for every lane at once:

- whether operands are signed or unsigned;
- whether the second operand is added or subtracted;
- whether an out-of-range lane wraps modulo its width or is clamped to the nearest extreme value.

Subtraction inverts the second operand and injects a carry of one at the bottom of each lane.

Results and per-lane overflow flags are captured in one output register stage. They appear one clock after a valid input. The block serves media and signal-processing datapaths that clip audio samples or pixel values instead of letting them roll over.

Top module: `simd_sat_adder`

## Requirements
- R1: `out_valid` rises in the clock after `in_valid` and is low otherwise. A synchronous reset clears `out_valid`, `sum` and `ovf` to zero.
- R2: `lane_mode` 2'b00 selects 8-bit lanes, 2'b01 selects 16-bit lanes, 2'b10 selects 32-bit lanes and 2'b11 selects one 64-bit lane. Lane i occupies bits [i*w+w-1 : i*w]. A carry out of one lane never reaches the next lane.
- R3: With `is_sub` = 1 each lane computes a + ~b + 1, which is a - b modulo 2^w.
- R4: Unsigned overflow in a lane has two cases. For addition it is the carry out of the lane's top bit. For subtraction it is b > a, taken as unsigned lane values.
- R5: Signed addition overflows only when both operands share a sign and the result sign differs. Signed subtraction overflows only when the operand signs differ and the result sign differs from the sign of a.
- R6: `ovf` has one bit per byte position. A lane's flag sits at the bit of its most significant byte, for example bits 1, 3, 5 and 7 in 16-bit mode. All other bits read 0.
- R7: With `saturate` = 0 every lane returns the wrapped modular result, even when it overflows.
- R8: With `saturate` = 1 and signed operation, a lane that overflows upward returns 0 followed by all ones. A lane that overflows downward returns 1 followed by all zeros.
- R9: With `saturate` = 1 and unsigned operation, an addition overflow returns all ones and a subtraction underflow returns zero.
- R10: In saturating mode, lanes that do not overflow return their exact result. The overflow flags are the same as in wrapping mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand vector |
| op_b | input | 64 | Second operand vector |
| lane_mode | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| is_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned lanes |
| is_sub | input | 1 | 1 = a - b, 0 = a + b |
| saturate | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| out_valid | output | 1 | Registered result is valid |
| sum | output | 64 | Registered lane results |
| ovf | output | 8 | Registered overflow flag per byte position (lane top byte) |

## Verification
Carry isolation at a lane edge and clamping of a lane can both fall in one cycle. When a lower lane overflows, it produces the very carry that must be dropped at the boundary, while the same lane is being forced to its extreme value. The bench provokes this with vectors where one lane overflows beside a neighbour that sits exactly at its own edge value (0x..FF or 0x7F..). A leaked carry would shift that neighbour by one. Every result is compared with a lane-by-lane model that computes the exact integer result at wider precision and then wraps or clamps it.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    LW8  = 2'b00,
    LW16 = 2'b01,
    LW32 = 2'b10,
    LW64 = 2'b11
  } lane_w_e;
endpackage

// File: rtl/simd_lane_decode.sv
module simd_lane_decode
  import simd_add_pkg::*;
#(
  parameter int NSLICE = 8,
  localparam int IDX_W = $clog2(NSLICE)
) (
  input  lane_w_e                       mode,
  output logic [NSLICE-1:0]             is_bottom,
  output logic [NSLICE-1:0]             is_top,
  output logic [NSLICE-1:0][IDX_W-1:0]  top_idx
);
  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    always_comb begin
      int span;
      int top;
      span = 1 << int'(mode);
      if (span > NSLICE) span = NSLICE;
      top = k | (span - 1);
      is_top[k]    = (top == k);
      is_bottom[k] = ((k % span) == 0);
      top_idx[k]   = IDX_W'(top);
    end
  end
endmodule

// File: rtl/simd_carry_chain.sv
module simd_carry_chain #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 8,
  localparam int DATA_W = SLICE_W * NSLICE
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_eff,
  input  logic [NSLICE-1:0] is_bottom,
  input  logic              lane_cin,
  output logic [DATA_W-1:0] raw,
  output logic [NSLICE-1:0] cout
);
  logic [NSLICE-1:0] cin;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    if (k == 0) begin : g_first
      assign cin[k] = lane_cin;
    end else begin : g_rest
      // the chain is cut where a new lane starts
      assign cin[k] = is_bottom[k] ? lane_cin : cout[k-1];
    end
    assign {cout[k], raw[k*SLICE_W +: SLICE_W]} =
      {1'b0, a[k*SLICE_W +: SLICE_W]} + {1'b0, b_eff[k*SLICE_W +: SLICE_W]} +
      {{SLICE_W{1'b0}}, cin[k]};
  end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 8,
  localparam int DATA_W = SLICE_W * NSLICE,
  localparam int IDX_W  = $clog2(NSLICE)
) (
  input  logic [DATA_W-1:0]             a,
  input  logic [DATA_W-1:0]             b_eff,
  input  logic [DATA_W-1:0]             raw,
  input  logic [NSLICE-1:0]             cout,
  input  logic [NSLICE-1:0]             is_top,
  input  logic [NSLICE-1:0][IDX_W-1:0]  top_idx,
  input  logic                          is_signed,
  input  logic                          is_sub,
  input  logic                          saturate,
  output logic [DATA_W-1:0]             result,
  output logic [NSLICE-1:0]             ovf_flag
);
  logic [NSLICE-1:0] low_side;

  for (genvar k = 0; k < NSLICE; k++) begin : g_flag
    logic a_s, b_s, r_s, s_ovf, u_ovf;
    assign a_s   = a[k*SLICE_W + SLICE_W - 1];
    assign b_s   = b_eff[k*SLICE_W + SLICE_W - 1];
    assign r_s   = raw[k*SLICE_W + SLICE_W - 1];
    assign s_ovf = (a_s == b_s) && (r_s != a_s);
    assign u_ovf = is_sub ^ cout[k];
    assign ovf_flag[k] = is_top[k] & (is_signed ? s_ovf : u_ovf);
    // clamp direction: toward the minimum or toward the maximum
    assign low_side[k] = is_signed ? a_s : is_sub;
  end

  for (genvar j = 0; j < NSLICE; j++) begin : g_fill
    always_comb begin
      logic [IDX_W-1:0]   t;
      logic [SLICE_W-1:0] fill;
      t = top_idx[j];
      if (is_signed && (int'(t) == j))
        fill = low_side[t] ? {1'b1, {(SLICE_W-1){1'b0}}} : {1'b0, {(SLICE_W-1){1'b1}}};
      else
        fill = low_side[t] ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}};
      result[j*SLICE_W +: SLICE_W] =
        (saturate && ovf_flag[t]) ? fill : raw[j*SLICE_W +: SLICE_W];
    end
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_add_pkg::*;
#(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 8,
  localparam int DATA_W = SLICE_W * NSLICE,
  localparam int IDX_W  = $clog2(NSLICE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        lane_mode,
  input  logic              is_signed,
  input  logic              is_sub,
  input  logic              saturate,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum,
  output logic [NSLICE-1:0] ovf
);
  lane_w_e                       mode;
  logic [NSLICE-1:0]             is_bottom, is_top;
  logic [NSLICE-1:0][IDX_W-1:0]  top_idx;
  logic [DATA_W-1:0]             b_eff, raw, result;
  logic [NSLICE-1:0]             cout, ovf_flag;

  assign mode  = lane_w_e'(lane_mode);
  assign b_eff = is_sub ? ~op_b : op_b;

  simd_lane_decode #(.NSLICE(NSLICE)) u_dec (
    .mode(mode), .is_bottom(is_bottom), .is_top(is_top), .top_idx(top_idx)
  );

  simd_carry_chain #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_chain (
    .a(op_a), .b_eff(b_eff), .is_bottom(is_bottom), .lane_cin(is_sub),
    .raw(raw), .cout(cout)
  );

  simd_lane_sat #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_sat (
    .a(op_a), .b_eff(b_eff), .raw(raw), .cout(cout), .is_top(is_top),
    .top_idx(top_idx), .is_signed(is_signed), .is_sub(is_sub),
    .saturate(saturate), .result(result), .ovf_flag(ovf_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum <= result;
        ovf <= ovf_flag;
      end
    end
  end

  // R1: result register follows the valid strobe by one cycle
  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6: flags only at the top byte of each lane
  p_flag_pos_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && lane_mode == 2'b01 |=> (ovf & 8'h55) == 8'h00);

  // R7: wrapping full-width result matches modular arithmetic
  p_wrap_full_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !saturate && lane_mode == 2'b11 |=>
      sum == ($past(is_sub) ? $past(op_a) - $past(op_b) : $past(op_a) + $past(op_b)));

  // R9: unsigned full-width clamps
  p_usat_add_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && saturate && !is_signed && !is_sub && lane_mode == 2'b11 |=>
      (!ovf[NSLICE-1] || sum == {DATA_W{1'b1}}));
  p_usat_sub_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && saturate && !is_signed && is_sub && lane_mode == 2'b11 |=>
      (!ovf[NSLICE-1] || sum == '0));

  // R8: signed full-width positive clamp
  p_ssat_pos_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && saturate && is_signed && lane_mode == 2'b11 && !op_a[DATA_W-1] |=>
      (!ovf[NSLICE-1] || sum == {1'b0, {(DATA_W-1){1'b1}}}));
endmodule

// File: tb/sim_simd_sat_adder.sv
module sim_simd_sat_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_mode = 2'b00;
  logic        is_signed = 1'b0, is_sub = 1'b0, saturate = 1'b0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] s;
    logic [7:0]  f;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  simd_sat_adder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_mode(lane_mode), .is_signed(is_signed), .is_sub(is_sub),
    .saturate(saturate), .out_valid(out_valid), .sum(sum), .ovf(ovf)
  );

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic sg, input logic sb,
                                input logic st, output logic [63:0] s,
                                output logic [7:0] f);
    int w;
    int nl;
    w  = 8 << m;
    nl = 64 / w;
    s  = '0;
    f  = '0;
    for (int i = 0; i < nl; i++) begin
      logic [63:0] la, lb, res;
      logic signed [67:0] ea, eb, ex, mx, mn, one;
      logic o;
      la = a >> (i * w);
      lb = b >> (i * w);
      if (w < 64) begin
        la = la & ((64'd1 << w) - 64'd1);
        lb = lb & ((64'd1 << w) - 64'd1);
      end
      one = 68'sd1;
      ea = $signed({4'b0, la});
      eb = $signed({4'b0, lb});
      if (sg) begin
        if (la[w-1]) ea = ea - (one <<< w);
        if (lb[w-1]) eb = eb - (one <<< w);
        mx = (one <<< (w - 1)) - one;
        mn = -(one <<< (w - 1));
      end else begin
        mx = (one <<< w) - one;
        mn = 68'sd0;
      end
      ex = sb ? ea - eb : ea + eb;
      o  = (ex > mx) || (ex < mn);
      if (st && ex > mx) ex = mx;
      else if (st && ex < mn) ex = mn;
      res = ex[63:0];
      if (w < 64) res = res & ((64'd1 << w) - 64'd1);
      s = s | (res << (i * w));
      f[i * (w / 8) + (w / 8) - 1] = o;
    end
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                       input logic sg, input logic sb, input logic st, input string tag);
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; lane_mode = m;
    is_signed = sg; is_sub = sb; saturate = st;
    in_valid = 1'b1;
    model(a, b, m, sg, sb, st, e.s, e.f);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (sum !== e.s || ovf !== e.f) begin
          errors++;
          $display("FAIL %s sum=%h ovf=%b expected sum=%h ovf=%b",
                   e.tag, sum, ovf, e.s, e.f);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sum !== '0 || ovf !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual=%b/%h/%b expected=0/0/0", out_valid, sum, ovf);
    end
    rst = 1'b0;
    idle(2);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle out_valid actual=%b expected=0", out_valid);
    end

    // R2: carries stop at byte edges
    drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 0, 0, 0, "R2");
    drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b01, 0, 0, 0, "R2");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 0, 0, 0, "R2");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 0, 0, 0, "R2");
    // R3: subtraction per lane
    drive(64'h1234_0000_8000_0005, 64'h0034_0001_0001_0007, 2'b01, 0, 1, 0, "R3");
    // R4: unsigned overflow and borrow
    drive(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 2'b10, 0, 0, 0, "R4");
    drive(64'h0000_0001_0000_0005, 64'h0000_0002_0000_0005, 2'b10, 0, 1, 0, "R4");
    // R5: signed add/sub overflow cases
    drive(64'h7F80_7F80_017F_80FF, 64'h0180_80FF_FF01_7F01, 2'b00, 1, 0, 0, "R5");
    drive(64'h807F_0080_7F00_7F80, 64'h0180_8001_FF01_8080, 2'b00, 1, 1, 0, "R5");
    // R6: flag placement per mode
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, "R6");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 2'b10, 0, 0, 0, "R6");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 0, 0, 0, "R6");
    // R7: wrapping on overflow
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1, 0, 0, "R7");
    // R8: signed clamps in both directions
    drive(64'h7FFF_8000_7000_9000, 64'h0001_FFFF_2000_E000, 2'b01, 1, 0, 1, "R8");
    drive(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'b10, 1, 1, 1, "R8");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 1, 0, 1, "R8");
    // R9: unsigned clamps
    drive(64'hF0F0_0101_FF00_80FE, 64'h2020_0202_0101_8003, 2'b00, 0, 0, 1, "R9");
    drive(64'h0102_0304_0506_0708, 64'h0203_0304_0405_0908, 2'b00, 0, 1, 1, "R9");
    drive(64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 2'b11, 0, 0, 1, "R9");
    drive(64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 2'b11, 0, 1, 1, "R9");
    // R10: lower lane clamps while neighbour sits at its edge value
    drive(64'h7FFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 2'b10, 0, 0, 1, "R10");
    drive(64'h7F7F_FF7F_00FF_7F10, 64'h0000_0101_0001_0120, 2'b00, 1, 0, 1, "R10");
    idle(2);
    // random sweep over every mode and control combination
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 4 == 1) rb = ~ra;
      drive(ra, rb, 2'(i % 4), 1'((i >> 2) & 1), 1'((i >> 3) & 1), 1'((i >> 4) & 1), "R10");
      if (i % 37 == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual=%0d expected=0", sb_q.size());
    end
    report();
  end
endmodule